// File: doc/BRIEF.md
# Stack Pair Sequencer

This block moves 16-bit register pairs between its own pair registers and a byte-wide stack memory, addressed by a 16-bit stack pointer. It takes one opcode at a time, along with an immediate word that the surrounding fetch logic has already collected. It then runs a fixed-length sequence of memory accesses and pointer steps. Pushes and pops cover the pairs BC, DE and HL, and also a word made of the accumulator and the flags.

Besides pushes and pops, the block can load the stack pointer from the immediate word, copy HL into the stack pointer, step the stack pointer up or down, and swap HL with the two bytes at the top of the stack. The stack grows toward lower addresses. The memory port is synchronous: read data appears one clock after its address. The four pairs and the stack pointer are visible as output ports. New pair values appear only when a sequence finishes.

Top module: `stk_seq`

## Requirements
- R1: After reset all four pairs and the stack pointer are 0x0000, `busy_o` is low and `mem_we_o` is low.
- R2: Opcode `11pp0101` is a push and `11pp0001` is a pop. The field pp at bits 5:4 selects the pair: 00 = BC, 01 = DE, 10 = HL, 11 = accumulator and flags.
- R3: A push keeps `busy_o` high for 11 cycles. In busy cycle 0 the stack pointer decrements. In cycle 1 the high byte is written at the stack pointer. In cycle 2 the stack pointer decrements again. In cycle 3 the low byte is written. The stack pointer ends 2 lower.
- R4: A pop keeps `busy_o` high for 10 cycles. It reads the low byte at the stack pointer, increments, reads the high byte, and increments again. The selected pair takes its new value on the edge where `busy_o` falls, and the stack pointer ends 2 higher.
- R5: In the accumulator-and-flags word the accumulator is bits 15:8 (the byte at the higher address) and the flags are bits 7:0.
- R6: Opcode 0xE3 keeps `busy_o` high for 18 cycles. It reads both bytes at SP and SP+1 before it writes the old L to SP and the old H to SP+1. HL then holds the old stack word. SP+1 wraps from 0xFFFF to 0x0000.
- R7: Opcode 0xF9 keeps `busy_o` high for 5 cycles and copies HL into the stack pointer.
- R8: Opcode 0x31 keeps `busy_o` high for 10 cycles and loads the stack pointer with the `imm_i` value sampled when the opcode is accepted.
- R9: Opcode 0x33 increments the stack pointer and opcode 0x3B decrements it. Each keeps `busy_o` high for 5 cycles, and both wrap modulo 2^16.
- R10: An opcode presented while `busy_o` is high is ignored, and so is any opcode not listed in R2 and R6 to R9. Neither one starts a sequence or changes the stack pointer.
- R11: `mem_we_o` is low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Opcode offered this cycle |
| op_i | input | 8 | Opcode |
| imm_i | input | 16 | Immediate word for the stack-pointer load |
| busy_o | output | 1 | A sequence is running |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read byte, one cycle after its address |
| bc_o | output | 16 | Pair BC |
| de_o | output | 16 | Pair DE |
| hl_o | output | 16 | Pair HL |
| af_o | output | 16 | Accumulator (high) and flags (low) |
| sp_o | output | 16 | Stack pointer |

## Verification
The bench builds the block with its default byte width of 8. That gives a 16-bit stack pointer and the default cycle counts, so the edge of the address space can be reached in a few operations. A swap with the stack pointer at 0xFFFF reaches across the wrap to address 0x0000, and a decrement from 0x0000 lands on 0xFFFF. The bench also pops a word preloaded at the high end of memory into every pair, and offers a second opcode in the middle of a pop to exercise the ignore rule.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_PUSH, K_POP, K_XCHG, K_HL2SP, K_LDSP, K_INC, K_DEC
  } op_kind_e;
  localparam logic [1:0] PAIR_HL = 2'd2;
endpackage

// File: rtl/stk_seq_decode.sv
module stk_seq_decode
  import stk_seq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int PUSH_CYC  = 11,
  parameter int POP_CYC   = 10,
  parameter int XCHG_CYC  = 18,
  parameter int HL2SP_CYC = 5,
  parameter int LDSP_CYC  = 10,
  parameter int STEP_CYC  = 5
) (
  input  logic [7:0]       opcode_i,
  output op_kind_e         kind_o,
  output logic [1:0]       pair_o,
  output logic [CNT_W-1:0] len_o
);
  always_comb begin
    pair_o = opcode_i[5:4];
    kind_o = K_NONE;
    len_o  = '0;
    if (opcode_i[7:6] == 2'b11 && opcode_i[3:0] == 4'b0101) begin
      kind_o = K_PUSH; len_o = CNT_W'(PUSH_CYC);
    end else if (opcode_i[7:6] == 2'b11 && opcode_i[3:0] == 4'b0001) begin
      kind_o = K_POP;  len_o = CNT_W'(POP_CYC);
    end else begin
      unique case (opcode_i)
        8'hE3: begin kind_o = K_XCHG;  len_o = CNT_W'(XCHG_CYC);  end
        8'hF9: begin kind_o = K_HL2SP; len_o = CNT_W'(HL2SP_CYC); end
        8'h31: begin kind_o = K_LDSP;  len_o = CNT_W'(LDSP_CYC);  end
        8'h33: begin kind_o = K_INC;   len_o = CNT_W'(STEP_CYC);  end
        8'h3B: begin kind_o = K_DEC;   len_o = CNT_W'(STEP_CYC);  end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_seq_timer.sv
module stk_seq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  logic             busy_q;
  logic [CNT_W-1:0] idx_q, len_q;

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign last_o = busy_q && (idx_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      len_q  <= len_i;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        idx_q  <= idx_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PUSH_CYC  = 11,
  parameter int POP_CYC   = 10,
  parameter int XCHG_CYC  = 18,
  parameter int HL2SP_CYC = 5,
  parameter int LDSP_CYC  = 10,
  parameter int STEP_CYC  = 5,
  localparam int PAIR_W   = 2 * BYTE_W,
  localparam int CNT_W    = $clog2(XCHG_CYC + PUSH_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [7:0]        op_i,
  input  logic [PAIR_W-1:0] imm_i,
  output logic              busy_o,
  output logic [PAIR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [PAIR_W-1:0] bc_o,
  output logic [PAIR_W-1:0] de_o,
  output logic [PAIR_W-1:0] hl_o,
  output logic [PAIR_W-1:0] af_o,
  output logic [PAIR_W-1:0] sp_o
);
  op_kind_e         dec_kind, kind_q;
  logic [1:0]       dec_pair, rp_q;
  logic [CNT_W-1:0] dec_len, idx;
  logic             busy, last, accept;
  logic [PAIR_W-1:0] pair_q [4];
  logic [PAIR_W-1:0] sp_q, imm_q, sel, sp_up;
  logic [BYTE_W-1:0] lo_q, hi_q;

  stk_seq_decode #(
    .CNT_W(CNT_W), .PUSH_CYC(PUSH_CYC), .POP_CYC(POP_CYC), .XCHG_CYC(XCHG_CYC),
    .HL2SP_CYC(HL2SP_CYC), .LDSP_CYC(LDSP_CYC), .STEP_CYC(STEP_CYC)
  ) u_dec (
    .opcode_i(op_i), .kind_o(dec_kind), .pair_o(dec_pair), .len_o(dec_len)
  );

  assign accept = op_valid_i && !busy && (dec_kind != K_NONE);

  stk_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .start_i(accept), .len_i(dec_len),
    .busy_o(busy), .idx_o(idx), .last_o(last)
  );

  assign sel   = pair_q[rp_q];
  assign sp_up = sp_q + PAIR_W'(1);

  // memory port
  always_comb begin
    mem_addr_o  = sp_q;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    if (busy) begin
      unique case (kind_q)
        K_PUSH: begin
          if (idx == CNT_W'(1)) begin mem_we_o = 1'b1; mem_wdata_o = sel[PAIR_W-1:BYTE_W]; end
          if (idx == CNT_W'(3)) begin mem_we_o = 1'b1; mem_wdata_o = sel[BYTE_W-1:0]; end
        end
        K_XCHG: begin
          if (idx == CNT_W'(1)) mem_addr_o = sp_up;
          if (idx == CNT_W'(3)) begin mem_we_o = 1'b1; mem_wdata_o = pair_q[PAIR_HL][BYTE_W-1:0]; end
          if (idx == CNT_W'(4)) begin
            mem_addr_o = sp_up; mem_we_o = 1'b1; mem_wdata_o = pair_q[PAIR_HL][PAIR_W-1:BYTE_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= K_NONE;
      rp_q   <= '0;
      imm_q  <= '0;
      sp_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      for (int i = 0; i < 4; i++) pair_q[i] <= '0;
    end else if (accept) begin
      kind_q <= dec_kind;
      rp_q   <= dec_pair;
      imm_q  <= imm_i;
    end else if (busy) begin
      unique case (kind_q)
        K_PUSH: if (idx == CNT_W'(0) || idx == CNT_W'(2)) sp_q <= sp_q - PAIR_W'(1);
        K_POP: begin
          if (idx == CNT_W'(1)) begin lo_q <= mem_rdata_i; sp_q <= sp_up; end
          if (idx == CNT_W'(3)) begin hi_q <= mem_rdata_i; sp_q <= sp_up; end
          if (last) pair_q[rp_q] <= {hi_q, lo_q};
        end
        K_XCHG: begin
          if (idx == CNT_W'(1)) lo_q <= mem_rdata_i;
          if (idx == CNT_W'(2)) hi_q <= mem_rdata_i;
          if (last) pair_q[PAIR_HL] <= {hi_q, lo_q};
        end
        K_HL2SP: if (last) sp_q <= pair_q[PAIR_HL];
        K_LDSP:  if (last) sp_q <= imm_q;
        K_INC:   if (last) sp_q <= sp_up;
        K_DEC:   if (last) sp_q <= sp_q - PAIR_W'(1);
        default: ;
      endcase
    end
  end

  assign busy_o = busy;
  assign bc_o   = pair_q[0];
  assign de_o   = pair_q[1];
  assign hl_o   = pair_q[2];
  assign af_o   = pair_q[3];
  assign sp_o   = sp_q;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int PAIR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [7:0]        op_i,
  input logic              busy_o,
  input logic [PAIR_W-1:0] mem_addr_o,
  input logic              mem_we_o,
  input logic [PAIR_W-1:0] bc_o,
  input logic [PAIR_W-1:0] de_o,
  input logic [PAIR_W-1:0] hl_o,
  input logic [PAIR_W-1:0] af_o,
  input logic [PAIR_W-1:0] sp_o
);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);

  p_write_near_sp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == sp_o || mem_addr_o == sp_o + PAIR_W'(1)));

  p_pairs_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(bc_o) || !$stable(de_o) || !$stable(hl_o) || !$stable(af_o)) |-> $fell(busy_o));

  p_push_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_i[7:6] == 2'b11 && op_i[3:0] == 4'b0101) |=> busy_o);

  p_junk_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !busy_o && op_i == 8'h00) |=> (!busy_o && $stable(sp_o)));

  p_sp_single_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o && !$stable(sp_o)) |->
      (sp_o == $past(sp_o) + PAIR_W'(1) || sp_o == $past(sp_o) - PAIR_W'(1)));
endmodule

bind stk_seq stk_seq_chk #(.PAIR_W(2 * BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
  .busy_o(busy_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o), .af_o(af_o), .sp_o(sp_o)
);

// File: tb/tb_stk_seq.sv
module tb_stk_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op = '0;
  logic [15:0] imm = '0;
  logic busy, mem_we;
  logic [15:0] mem_addr, bc, de, hl, af, sp;
  logic [7:0] mem_wdata, mem_rdata = '0;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  stk_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .imm_i(imm),
    .busy_o(busy), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .bc_o(bc), .de_o(de), .hl_o(hl), .af_o(af), .sp_o(sp)
  );

  // memory model
  logic [7:0] mem [65536];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // reference model: kinds 0 none,1 push,2 pop,3 swap,4 hl->sp,5 load,6 inc,7 dec
  int m_busy, m_kind, m_idx, m_len, m_rp, m_imm, m_lo, m_hi, m_sp;
  int m_pair [4];

  function automatic int kind_of(input logic [7:0] o);
    if (o inside {8'hC5, 8'hD5, 8'hE5, 8'hF5}) return 1;
    if (o inside {8'hC1, 8'hD1, 8'hE1, 8'hF1}) return 2;
    if (o == 8'hE3) return 3;
    if (o == 8'hF9) return 4;
    if (o == 8'h31) return 5;
    if (o == 8'h33) return 6;
    if (o == 8'h3B) return 7;
    return 0;
  endfunction

  function automatic int len_of(input int k);
    case (k)
      1: return 11; 2: return 10; 3: return 18; 5: return 10;
      default: return 5;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_kind = 0; m_idx = 0; m_len = 0; m_rp = 0; m_imm = 0;
      m_lo = 0; m_hi = 0; m_sp = 0;
      for (int i = 0; i < 4; i++) m_pair[i] = 0;
    end else if (m_busy != 0) begin
      case (m_kind)
        1: if (m_idx == 0 || m_idx == 2) m_sp = (m_sp + 65535) % 65536;
        2: begin
          if (m_idx == 1) begin m_lo = int'(mem_rdata); m_sp = (m_sp + 1) % 65536; end
          if (m_idx == 3) begin m_hi = int'(mem_rdata); m_sp = (m_sp + 1) % 65536; end
        end
        3: begin
          if (m_idx == 1) m_lo = int'(mem_rdata);
          if (m_idx == 2) m_hi = int'(mem_rdata);
        end
        default: ;
      endcase
      if (m_idx == m_len - 1) begin
        case (m_kind)
          2: m_pair[m_rp] = m_hi * 256 + m_lo;
          3: m_pair[2] = m_hi * 256 + m_lo;
          4: m_sp = m_pair[2];
          5: m_sp = m_imm;
          6: m_sp = (m_sp + 1) % 65536;
          7: m_sp = (m_sp + 65535) % 65536;
          default: ;
        endcase
        m_busy = 0;
      end else m_idx++;
    end else if (op_valid && kind_of(op) != 0) begin
      m_busy = 1; m_kind = kind_of(op); m_len = len_of(m_kind); m_idx = 0;
      m_rp = int'(op[5:4]); m_imm = int'(imm);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      string t;
      int e_we, e_addr, e_wd;
      case (m_busy ? m_kind : 0)
        1: t = "R3"; 2: t = "R4"; 3: t = "R6"; 4: t = "R7"; 5: t = "R8";
        6, 7: t = "R9"; default: t = "R11";
      endcase
      e_we = 0; e_addr = m_sp; e_wd = 0;
      if (m_busy != 0 && m_kind == 1 && m_idx == 1) begin e_we = 1; e_wd = m_pair[m_rp] / 256; end
      if (m_busy != 0 && m_kind == 1 && m_idx == 3) begin e_we = 1; e_wd = m_pair[m_rp] % 256; end
      if (m_busy != 0 && m_kind == 3) begin
        if (m_idx == 1) e_addr = (m_sp + 1) % 65536;
        if (m_idx == 3) begin e_we = 1; e_wd = m_pair[2] % 256; end
        if (m_idx == 4) begin e_we = 1; e_wd = m_pair[2] / 256; e_addr = (m_sp + 1) % 65536; end
      end
      check({t, " busy"}, int'(busy), m_busy);
      check({t, " we"}, int'(mem_we), e_we);
      check({t, " addr"}, int'(mem_addr), e_addr);
      if (e_we != 0) check({t, " wdata"}, int'(mem_wdata), e_wd);
      check({t, " sp"}, int'(sp), m_sp);
      check({t, " bc"}, int'(bc), m_pair[0]);
      check({t, " de"}, int'(de), m_pair[1]);
      check({t, " hl"}, int'(hl), m_pair[2]);
      check({t, " af"}, int'(af), m_pair[3]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input logic [7:0] o, input logic [15:0] v, input int exp_len, input string tag);
    int n;
    @(negedge clk); op_valid = 1'b1; op = o; imm = v;
    @(negedge clk); op_valid = 1'b0;
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check({tag, " cycles"}, n, exp_len);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    mem[16'hFFF0] = 8'h34; mem[16'hFFF1] = 8'h12;
    mem[16'hFFF2] = 8'h78; mem[16'hFFF3] = 8'h56;
    mem[16'hFFF4] = 8'hBC; mem[16'hFFF5] = 8'h9A;
    mem[16'hFFF6] = 8'h57; mem[16'hFFF7] = 8'hDE;
    mem[16'hFFFF] = 8'h11; mem[16'h0000] = 8'h22; mem[16'h0001] = 8'h33;
    repeat (3) @(negedge clk);
    check("R1 reset sp", int'(sp), 0);
    check("R1 reset pairs", int'(bc | de | hl | af), 0);
    check("R1 reset busy/we", int'(busy) + int'(mem_we), 0);
    rst_n = 1'b1;

    run(8'h31, 16'hFFF0, 10, "R8 load sp");
    check("R8 sp value", int'(sp), 16'hFFF0);
    run(8'hC1, 16'h0, 10, "R4 pop BC");
    run(8'hD1, 16'h0, 10, "R2 pop DE");
    run(8'hE1, 16'h0, 10, "R2 pop HL");
    run(8'hF1, 16'h0, 10, "R2 pop AF");
    check("R4 bc", int'(bc), 16'h1234);
    check("R2 de", int'(de), 16'h5678);
    check("R2 hl", int'(hl), 16'h9ABC);
    check("R5 af acc high", int'(af), 16'hDE57);
    check("R4 sp after pops", int'(sp), 16'hFFF8);

    run(8'hD5, 16'h0, 11, "R3 push DE");
    run(8'hF5, 16'h0, 11, "R5 push AF");
    check("R3 mem hi DE", int'(mem[16'hFFF7]), 8'h56);
    check("R3 mem lo DE", int'(mem[16'hFFF6]), 8'h78);
    check("R5 mem acc", int'(mem[16'hFFF5]), 8'hDE);
    check("R5 mem flags", int'(mem[16'hFFF4]), 8'h57);
    check("R3 sp after push", int'(sp), 16'hFFF4);

    run(8'hE3, 16'h0, 18, "R6 swap");
    check("R6 hl", int'(hl), 16'hDE57);
    check("R6 mem lo", int'(mem[16'hFFF4]), 8'hBC);
    check("R6 mem hi", int'(mem[16'hFFF5]), 8'h9A);

    run(8'hF9, 16'h0, 5, "R7 hl to sp");
    check("R7 sp", int'(sp), 16'hDE57);
    run(8'h33, 16'h0, 5, "R9 inc");
    run(8'h3B, 16'h0, 5, "R9 dec");
    run(8'h3B, 16'h0, 5, "R9 dec");
    check("R9 sp steps", int'(sp), 16'hDE56);

    run(8'h31, 16'hFFFF, 10, "R8 load top");
    run(8'hE3, 16'h0, 18, "R6 swap wrap");
    check("R6 wrap hl", int'(hl), 16'h2211);
    check("R6 wrap mem ffff", int'(mem[16'hFFFF]), 8'h57);
    check("R6 wrap mem 0000", int'(mem[16'h0000]), 8'hDE);

    run(8'h31, 16'h0000, 10, "R8 load zero");
    run(8'h3B, 16'h0, 5, "R9 dec wrap");
    check("R9 wrap down", int'(sp), 16'hFFFF);
    run(8'h33, 16'h0, 5, "R9 inc wrap");
    check("R9 wrap up", int'(sp), 16'h0000);

    // second opcode offered while busy
    @(negedge clk); op_valid = 1'b1; op = 8'hF1;
    @(negedge clk); op = 8'hC5;
    @(negedge clk); op_valid = 1'b0;
    while (busy) @(negedge clk);
    check("R10 af after busy offer", int'(af), 16'h33DE);
    check("R10 sp no push", int'(sp), 16'h0002);
    check("R10 mem untouched", int'(mem[16'h0001]), 8'h33);

    run(8'h00, 16'h0, 0, "R10 junk op");
    run(8'h76, 16'h0, 0, "R10 junk op");
    check("R10 sp after junk", int'(sp), 16'h0002);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule